// File: doc/BRIEF.md
# Target Address Table

The block is a small register file that a bus controller keeps with one slot per attached target. Each slot holds a 7-bit static address, a 7-bit dynamic address with a parity bit that the hardware computes on every write, and a flag that marks the target as a legacy I2C device. Software reaches the slots through word-aligned offsets on a simple read/write port. A fixed pointer word at offset 0x00 tells software how many slots the table has and where in the offset space the table starts.

Beside the host port, the table serves the rest of the controller directly. An address lookup returns, in the same cycle, the lowest slot whose address matches. An occupancy bitmap feeds a priority search that names the lowest free slot. From that slot the block also builds the index and count fields of an address-assignment command, so that assignment starts at the first free slot and covers every slot above it.

Top module: `dat_table`

## Requirements
- R1: A read of offset 0x00 returns the slot count in bits 31:16 and the table base offset in bits 7:0, with all other bits zero. Writes to that offset have no effect.
- R2: Slot n sits at offset BASE + 4*n (default BASE 0x20, 8 slots). A write keeps bit 31 (legacy flag), bits 22:16 (dynamic address) and bits 6:0 (static address) and discards every other written bit. Read data appears on rdata in the cycle after the edge that samples rd_en.
- R3: Bit 23 of a stored slot is set when the dynamic address holds an even number of ones, zero included, and is cleared otherwise. The bit-23 value that is written is ignored.
- R4: A write whose legacy, dynamic and static fields are all zero frees the slot, and the slot then reads as zero. Any other write to a slot marks it occupied.
- R5: free_idx names the lowest free slot and free_valid is 1 while any slot is free. When every slot is occupied, free_valid is 0.
- R6: lookup_hit and lookup_idx follow lookup_addr combinationally. Only occupied slots take part. A legacy slot is compared on its static address and any other slot on its dynamic address. When several slots match, the lowest index is reported, and on a miss lookup_idx is 0.
- R7: assign_cmd carries the lowest free index in bits 20:16 and the slot count minus that index in bits 25:21, with all other bits zero. The whole word is zero when no slot is free.
- R8: Reads of an offset that is neither the pointer word nor an aligned slot return zero. Writes to such an offset change no slot.
- R9: Reset empties every slot and clears rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | AW | Host byte offset |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Registered host read data |
| lookup_addr | input | 7 | Address to search for |
| lookup_hit | output | 1 | A matching occupied slot exists |
| lookup_idx | output | IW | Lowest matching slot |
| free_valid | output | 1 | At least one slot is free |
| free_idx | output | IW | Lowest free slot |
| assign_cmd | output | 32 | Index and count fields for an address-assignment command |

## Verification
Host reads have one cycle of latency: rdata changes at the edge that samples rd_en. The bench raises the strobe at a falling edge and reads rdata at the next falling edge. A write takes effect at the rising edge that samples it, and the lookup, free-slot and assignment outputs are combinational from the stored table. The bench therefore checks them at the falling edge after a write, and checks a new lookup_addr a short delay after driving it, away from any rising edge. Because reset release passes through a two-stage synchroniser, the bench waits three cycles after release before it checks anything.

// File: rtl/dat_pkg.sv
package dat_pkg;

  // Stored layout of one table slot
  typedef struct packed {
    logic       legacy;   // bit 31
    logic [6:0] rsv_hi;   // bits 30:24
    logic       par;      // bit 23
    logic [6:0] dyn;      // bits 22:16
    logic [8:0] rsv_mid;  // bits 15:7
    logic [6:0] stat;     // bits 6:0
  } dat_entry_t;

  // True when the written word carries any field the slot keeps
  function automatic logic dat_claims(input logic [31:0] w);
    return w[31] | (|w[22:16]) | (|w[6:0]);
  endfunction

  // Build the stored slot from a host word; parity makes the 8-bit field odd
  function automatic dat_entry_t dat_pack(input logic [31:0] w);
    dat_entry_t e;
    e = '0;
    if (dat_claims(w)) begin
      e.legacy = w[31];
      e.dyn    = w[22:16];
      e.par    = ~^w[22:16];
      e.stat   = w[6:0];
    end
    return e;
  endfunction

endpackage

// File: rtl/dat_prio_enc.sv
module dat_prio_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dat_entry_store.sv
module dat_entry_store
  import dat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int BASE  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output dat_entry_t [DEPTH-1:0] ent_o,
  output logic [DEPTH-1:0]       occ_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [AW-1:0] OFF = AW'(BASE + 4 * g);

    logic       sel;
    dat_entry_t ent_d, ent_q;
    logic       occ_d, occ_q;

    assign sel = wr_en && (addr == OFF);

    always_comb begin
      ent_d = dat_pack(wdata);
      occ_d = dat_claims(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
        occ_q <= 1'b0;
      end else if (sel) begin
        ent_q <= ent_d;
        occ_q <= occ_d;
      end
    end

    assign ent_o[g] = ent_q;
    assign occ_o[g] = occ_q;
  end

endmodule

// File: rtl/dat_table.sv
module dat_table
  import dat_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AW      = 8,
  parameter int BASE    = 32,
  parameter int PTR_OFF = 0,
  localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [6:0]    lookup_addr,
  output logic          lookup_hit,
  output logic [IW-1:0] lookup_idx,
  output logic          free_valid,
  output logic [IW-1:0] free_idx,
  output logic [31:0]   assign_cmd
);

  localparam logic [31:0] PTR_WORD = {16'(DEPTH), 8'h00, 8'(BASE)};

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Slot storage
  dat_entry_t [DEPTH-1:0] ent_vec;
  logic [DEPTH-1:0]       occ_vec;

  dat_entry_store #(.DEPTH(DEPTH), .AW(AW), .BASE(BASE)) store_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .ent_o (ent_vec),
    .occ_o (occ_vec)
  );

  // Host read path
  logic [31:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    if (addr == AW'(PTR_OFF)) rd_d = PTR_WORD;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == AW'(BASE + 4 * i)) rd_d = ent_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_d;
  end
  assign rdata = rdata_q;

  // Parallel address match
  logic [DEPTH-1:0] match_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    logic [6:0] cand;
    assign cand         = ent_vec[g].legacy ? ent_vec[g].stat : ent_vec[g].dyn;
    assign match_vec[g] = occ_vec[g] && (cand == lookup_addr);
  end

  dat_prio_enc #(.N(DEPTH), .IW(IW)) match_enc_i (
    .req   (match_vec),
    .found (lookup_hit),
    .idx   (lookup_idx)
  );

  // Lowest free slot
  dat_prio_enc #(.N(DEPTH), .IW(IW)) free_enc_i (
    .req   (~occ_vec),
    .found (free_valid),
    .idx   (free_idx)
  );

  // Address-assignment fields: start slot and number of slots above it
  logic [4:0] span;
  always_comb begin
    span       = 5'(DEPTH) - 5'(free_idx);
    assign_cmd = '0;
    if (free_valid) begin
      assign_cmd[25:21] = span;
      assign_cmd[20:16] = 5'(free_idx);
    end
  end

endmodule

// File: rtl/dat_table_chk.sv
module dat_table_chk #(
  parameter int DEPTH   = 8,
  parameter int IW      = 3,
  parameter int AW      = 8,
  parameter int BASE    = 32,
  parameter int PTR_OFF = 0
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      rdata,
  input logic             lookup_hit,
  input logic [IW-1:0]    lookup_idx,
  input logic             free_valid,
  input logic [IW-1:0]    free_idx,
  input logic [31:0]      assign_cmd,
  input logic [DEPTH-1:0] occ_vec
);

  localparam logic [31:0] PTR_WORD = {16'(DEPTH), 8'h00, 8'(BASE)};

  logic in_tab, is_ptr;
  always_comb begin
    in_tab = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == AW'(BASE + 4 * i)) in_tab = 1'b1;
    end
    is_ptr = (addr == AW'(PTR_OFF));
  end

  // R1
  ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && is_ptr) |=> (rdata == PTR_WORD));

  // R3
  parity_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && in_tab) |=> ((rdata == 32'h0) || (rdata[23] == ~^rdata[22:16])));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !in_tab && !is_ptr) |=> (rdata == 32'h0));

  // R6
  lookup_occ_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lookup_hit |-> occ_vec[lookup_idx]);

  // R5
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    free_valid |-> !occ_vec[free_idx]);

  // R5
  full_table_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !free_valid |-> (&occ_vec));

  // R7
  assign_span_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    free_valid |-> ((6'(assign_cmd[25:21]) + 6'(assign_cmd[20:16])) == 6'(DEPTH)));

  // R7
  assign_full_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !free_valid |-> (assign_cmd == 32'h0));

endmodule

bind dat_table dat_table_chk #(
  .DEPTH(DEPTH), .IW(IW), .AW(AW), .BASE(BASE), .PTR_OFF(PTR_OFF)
) chk_i (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .rd_en      (rd_en),
  .addr       (addr),
  .rdata      (rdata),
  .lookup_hit (lookup_hit),
  .lookup_idx (lookup_idx),
  .free_valid (free_valid),
  .free_idx   (free_idx),
  .assign_cmd (assign_cmd),
  .occ_vec    (occ_vec)
);

// File: tb/dat_table_tb_top.sv
module dat_table_tb_top;

  localparam int DEPTH = 8;
  localparam int AW    = 8;
  localparam int BASE  = 32;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [6:0]    lookup_addr = '0;
  logic          lookup_hit;
  logic [IW-1:0] lookup_idx;
  logic          free_valid;
  logic [IW-1:0] free_idx;
  logic [31:0]   assign_cmd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dat_table #(.DEPTH(DEPTH), .AW(AW), .BASE(BASE), .PTR_OFF(0)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .lookup_addr (lookup_addr),
    .lookup_hit  (lookup_hit),
    .lookup_idx  (lookup_idx),
    .free_valid  (free_valid),
    .free_idx    (free_idx),
    .assign_cmd  (assign_cmd)
  );

  // Expected stored slot, per R2/R3/R4
  function automatic logic [31:0] exp_slot(input logic [31:0] w);
    logic [31:0] e;
    e = '0;
    if (w[31] || w[22:16] != 0 || w[6:0] != 0) begin
      e[31]    = w[31];
      e[22:16] = w[22:16];
      e[23]    = ($countones(w[22:16]) % 2) == 0;
      e[6:0]   = w[6:0];
    end
    return e;
  endfunction

  function automatic logic [AW-1:0] slot_off(input int n);
    return AW'(BASE + 4 * n);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic probe(input logic [6:0] a);
    lookup_addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R9 rdata after reset", rdata, 32'h0);
    check("R9 free_valid after reset", 32'(free_valid), 32'd1);
    check("R9 free_idx after reset", 32'(free_idx), 32'd0);
    probe(7'h00);
    check("R9 no hit on empty table", 32'(lookup_hit), 32'd0);
    host_rd(slot_off(0), d);
    check("R9 slot 0 empty", d, 32'h0);
  endtask

  task automatic t_pointer();
    logic [31:0] d;
    host_rd(8'h00, d);
    check("R1 pointer word", d, 32'h0008_0020);
    host_wr(8'h00, 32'hFFFF_FFFF);
    host_rd(8'h00, d);
    check("R1 pointer ignores write", d, 32'h0008_0020);
    check("R1 pointer write claims no slot", 32'(free_idx), 32'd0);
  endtask

  task automatic t_store_parity();
    logic [31:0] d;
    logic [31:0] pat [5];
    pat[0] = 32'h0008_0000;  // one bit set: parity 0
    pat[1] = 32'h0083_0000;  // two bits set, bit 23 written
    pat[2] = 32'h00FF_0000;  // seven bits set, bit 23 written
    pat[3] = 32'h8000_0050;  // legacy, dynamic zero: parity 1
    pat[4] = 32'hFFFF_FFFF;  // reserved bits dropped
    for (int n = 0; n < 5; n++) host_wr(slot_off(n), pat[n]);
    for (int n = 0; n < 5; n++) begin
      host_rd(slot_off(n), d);
      check($sformatf("R2 R3 slot %0d readback", n), d, exp_slot(pat[n]));
    end
    host_rd(slot_off(1), d);
    check("R3 even ones gives parity 1", 32'(d[23]), 32'd1);
    host_rd(slot_off(2), d);
    check("R3 odd ones gives parity 0", 32'(d[23]), 32'd0);
    host_rd(slot_off(4), d);
    check("R2 reserved bits dropped", d, 32'h807F_007F);
  endtask

  task automatic t_free_assign();
    logic [31:0] d;
    check("R5 lowest free after five", 32'(free_idx), 32'd5);
    check("R7 assign fields start 5 count 3", assign_cmd, 32'h0065_0000);
    host_wr(slot_off(5), 32'h0008_0000);
    host_wr(slot_off(6), 32'h0000_0022);
    host_wr(slot_off(7), 32'h0011_0000);
    check("R5 full table", 32'(free_valid), 32'd0);
    check("R7 assign zero when full", assign_cmd, 32'h0);
    host_rd(slot_off(7), d);
    check("R2 last slot offset", d, exp_slot(32'h0011_0000));
    host_wr(slot_off(2), 32'h0000_0000);
    check("R4 zero write frees slot", 32'(free_idx), 32'd2);
    check("R5 free_valid again", 32'(free_valid), 32'd1);
    check("R7 assign start 2 count 6", assign_cmd, 32'h00C2_0000);
    host_rd(slot_off(2), d);
    check("R4 freed slot reads zero", d, 32'h0);
    host_wr(slot_off(2), 32'h0080_FF80);
    check("R4 reserved-only write stays free", 32'(free_idx), 32'd2);
    host_rd(slot_off(2), d);
    check("R3 R4 reserved-only write reads zero", d, 32'h0);
  endtask

  task automatic t_lookup();
    probe(7'h03);
    check("R6 dynamic match hit", 32'(lookup_hit), 32'd1);
    check("R6 dynamic match idx", 32'(lookup_idx), 32'd1);
    probe(7'h50);
    check("R6 legacy static match idx", {31'(lookup_idx), lookup_hit}, {31'd3, 1'b1});
    probe(7'h7F);
    check("R6 legacy slot 4 static", {31'(lookup_idx), lookup_hit}, {31'd4, 1'b1});
    probe(7'h08);
    check("R6 lowest index wins", {31'(lookup_idx), lookup_hit}, {31'd0, 1'b1});
    probe(7'h22);
    check("R6 static ignored on non-legacy", {31'(lookup_idx), lookup_hit}, {31'd0, 1'b0});
    probe(7'h45);
    check("R6 miss", 32'(lookup_hit), 32'd0);
    host_wr(slot_off(0), 32'h0);
    probe(7'h08);
    check("R6 R4 freed slot drops out", {31'(lookup_idx), lookup_hit}, {31'd5, 1'b1});
    check("R5 slot 0 free again", 32'(free_idx), 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    host_rd(8'h04, d);
    check("R8 gap offset reads zero", d, 32'h0);
    host_rd(8'h21, d);
    check("R8 unaligned offset reads zero", d, 32'h0);
    host_wr(8'h21, 32'h0012_0012);
    host_wr(8'h04, 32'h0012_0012);
    host_wr(8'h40, 32'h0012_0012);
    check("R8 stray writes claim nothing", 32'(free_idx), 32'd0);
    host_rd(slot_off(0), d);
    check("R8 slot 0 untouched", d, 32'h0);
    host_rd(slot_off(1), d);
    check("R8 slot 1 untouched", d, exp_slot(32'h0083_0000));
  endtask

  task automatic t_reset_mid();
    logic [31:0] d;
    do_reset();
    check("R9 rdata cleared", rdata, 32'h0);
    check("R9 table emptied", {31'(free_idx), free_valid}, {31'd0, 1'b1});
    host_rd(slot_off(1), d);
    check("R9 slot 1 cleared", d, 32'h0);
    probe(7'h03);
    check("R9 lookup misses after reset", 32'(lookup_hit), 32'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_pointer();
    t_store_parity();
    t_free_assign();
    t_lookup();
    t_unmapped();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule